// File: doc/BRIEF.md
# Instruction Fetch Queue

This block is a small in-order instruction queue between a fetch stage and the dispatch logic. Each cycle it tells fetch how many instruction words it will take. That count is the number of free entries the queue held at the start of the cycle, capped at the four-lane width of the write port. Fetch returns up to four words on lane-indexed valid bits. The queue keeps the words it granted and drops the rest. Toward the execution units it offers the two oldest held words on two dispatch slots. Each slot has its own ready.

Streams follow valid/ready rules. On the fill side, `req_cnt` acts as a per-lane ready: lane i is taken only when i is below `req_cnt` and lanes 0..i are all valid. On the dispatch side, a slot's valid never depends on its ready. Slot 1 transfers only when slot 0 transfers in the same cycle, so the queue always drains from its head in order.

`throttle` suppresses fill requests while the queue keeps draining. `flush` discards every held word in one step, blocks fill and dispatch in its own cycle, and makes the following request a full one. The queue is a six-entry circular buffer.

Top module: `insn_queue`

## Requirements
- R1: After reset the queue is empty: both `disp_valid` bits are 0 and, without throttle or flush, `req_cnt` is 4.
- R2: Without throttle or flush, `req_cnt` equals min(free entries at the start of the cycle, 4), where free entries = 6 minus the words held.
- R3: While `throttle` is 1, `req_cnt` is 0 and no returned word enters the queue.
- R4: Lane i (bits [32*i+31:32*i] of `rsp_insn`, valid bit `rsp_valid[i]`) is accepted only if i < `req_cnt` and `rsp_valid[0..i]` are all 1; every other lane is ignored.
- R5: Accepted words leave through dispatch in fetch order, lower lanes first. A word accepted at an edge can appear at dispatch in the cycle after that edge.
- R6: `disp_valid[0]` is 1 when at least one word is held and carries the oldest word; `disp_valid[1]` is 1 when at least two are held and carries the second oldest. Bits [31:0] of `disp_insn` belong to slot 0.
- R7: Slot 0 transfers when its valid and ready are both 1. Slot 1 transfers only when it is valid and ready and slot 0 transfers in the same cycle; otherwise slot 1's word stays queued.
- R8: While `flush` is 1, `disp_valid` is 0 and `req_cnt` is 0. In the next cycle the queue is empty and, without throttle or flush, `req_cnt` is 4.
- R9: The number of held words never exceeds six, and dispatch never removes more words than are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| throttle | input | 1 | Suppresses fill requests |
| flush | input | 1 | Discards all held words |
| req_cnt | output | 3 | Number of lanes granted this cycle |
| rsp_valid | input | 4 | Per-lane valid of returned words |
| rsp_insn | input | 128 | Returned words, lane 0 in the low bits |
| disp_valid | output | 2 | Per-slot valid toward execution units |
| disp_ready | input | 2 | Per-slot ready from execution units |
| disp_insn | output | 64 | Slot words, slot 0 in the low bits |

## Verification
`req_cnt` and both dispatch slots are combinational views of state registered at the previous edge, together with the current `throttle`, `flush` and readies. The bench therefore drives inputs just after a falling edge and samples a few nanoseconds later in the same cycle, before the next rising edge. Words accepted and a flush take effect at the rising edge, so their effect on dispatch and on the next `req_cnt` is checked one cycle after the stimulus. An arithmetic model in the bench is updated in the same way. A sweep covers every lane-valid pattern against every ready pattern, with and without throttle, and with periodic flushes.

// File: rtl/iq_pkg.sv
`timescale 1ns/1ps
package iq_pkg;
  parameter int unsigned INSN_W = 32;
  typedef logic [INSN_W-1:0] insn_t;
endpackage

// File: rtl/iq_credit.sv
`timescale 1ns/1ps
module iq_credit #(
  parameter int DEPTH = 6,
  parameter int WR_W  = 4,
  parameter int CNT_W = 3,
  parameter int REQ_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             throttle,
  input  logic             flush,
  input  logic [CNT_W-1:0] next_free,
  output logic [REQ_W-1:0] req_cnt
);
  logic [CNT_W-1:0] free_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     free_q <= CNT_W'(DEPTH);
    else if (flush) free_q <= CNT_W'(DEPTH);
    else            free_q <= next_free;
  end

  always_comb begin
    if (throttle || flush)              req_cnt = '0;
    else if (free_q > CNT_W'(WR_W))     req_cnt = REQ_W'(WR_W);
    else                                req_cnt = REQ_W'(free_q);
  end
endmodule

// File: rtl/iq_accept.sv
`timescale 1ns/1ps
module iq_accept #(
  parameter int WR_W  = 4,
  parameter int REQ_W = 3
) (
  input  logic [WR_W-1:0]  lane_vld,
  input  logic [REQ_W-1:0] grant,
  output logic [REQ_W-1:0] take_n
);
  logic run;
  always_comb begin
    take_n = '0;
    run    = 1'b1;
    for (int i = 0; i < WR_W; i++) begin
      if (run && lane_vld[i] && (REQ_W'(i) < grant)) take_n = REQ_W'(i + 1);
      else run = 1'b0;
    end
  end
endmodule

// File: rtl/iq_ring.sv
`timescale 1ns/1ps
module iq_ring
  import iq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int WR_W  = 4,
  parameter int RD_W  = 2,
  parameter int CNT_W = 3,
  parameter int PTR_W = 3,
  parameter int REQ_W = 3,
  parameter int POP_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [REQ_W-1:0] push_n,
  input  insn_t            wr_data [WR_W],
  input  logic [POP_W-1:0] pop_n,
  output insn_t            rd_data [RD_W],
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cnt_nxt
);
  insn_t            mem [DEPTH];
  logic [PTR_W-1:0] head, tail;

  function automatic logic [PTR_W-1:0] wrap(input int base, input int off);
    int s;
    s = base + off;
    if (s >= DEPTH) s = s - DEPTH;
    return PTR_W'(s);
  endfunction

  always_comb begin
    if (flush) cnt_nxt = '0;
    else       cnt_nxt = count + CNT_W'(push_n) - CNT_W'(pop_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      head  <= wrap(32'(head), 32'(pop_n));
      tail  <= wrap(32'(tail), 32'(push_n));
      count <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < WR_W; i++)
      if (!flush && (REQ_W'(i) < push_n)) mem[wrap(32'(tail), i)] <= wr_data[i];
  end

  always_comb begin
    for (int j = 0; j < RD_W; j++) rd_data[j] = mem[wrap(32'(head), j)];
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R9
  pop_under_chk: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(pop_n) <= count);
endmodule

// File: rtl/insn_queue.sv
`timescale 1ns/1ps
module insn_queue
  import iq_pkg::*;
#(
  parameter  int DEPTH = 6,
  parameter  int WR_W  = 4,
  parameter  int RD_W  = 2,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH),
  localparam int REQ_W = $clog2(WR_W + 1),
  localparam int POP_W = $clog2(RD_W + 1),
  localparam int CAP   = (DEPTH < WR_W) ? DEPTH : WR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   throttle,
  input  logic                   flush,
  output logic [REQ_W-1:0]       req_cnt,
  input  logic [WR_W-1:0]        rsp_valid,
  input  logic [WR_W*INSN_W-1:0] rsp_insn,
  output logic [RD_W-1:0]        disp_valid,
  input  logic [RD_W-1:0]        disp_ready,
  output logic [RD_W*INSN_W-1:0] disp_insn
);
  logic [REQ_W-1:0] push_n;
  logic [POP_W-1:0] pop_n;
  logic [CNT_W-1:0] count, cnt_nxt, next_free;
  logic [RD_W-1:0]  fire;
  insn_t            wr_data [WR_W];
  insn_t            rd_data [RD_W];

  assign next_free = CNT_W'(DEPTH) - cnt_nxt;

  iq_credit #(.DEPTH(DEPTH), .WR_W(WR_W), .CNT_W(CNT_W), .REQ_W(REQ_W)) u_credit (
    .clk(clk), .rst_n(rst_n), .throttle(throttle), .flush(flush),
    .next_free(next_free), .req_cnt(req_cnt));

  iq_accept #(.WR_W(WR_W), .REQ_W(REQ_W)) u_accept (
    .lane_vld(rsp_valid), .grant(req_cnt), .take_n(push_n));

  iq_ring #(.DEPTH(DEPTH), .WR_W(WR_W), .RD_W(RD_W), .CNT_W(CNT_W), .PTR_W(PTR_W),
            .REQ_W(REQ_W), .POP_W(POP_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push_n(push_n), .wr_data(wr_data),
    .pop_n(pop_n), .rd_data(rd_data), .count(count), .cnt_nxt(cnt_nxt));

  for (genvar i = 0; i < WR_W; i++) begin : g_lane
    assign wr_data[i] = rsp_insn[i*INSN_W +: INSN_W];
  end

  for (genvar j = 0; j < RD_W; j++) begin : g_slot
    assign disp_valid[j]              = !flush && (CNT_W'(j) < count);
    assign disp_insn[j*INSN_W +: INSN_W] = rd_data[j];
    if (j == 0) begin : g_first
      assign fire[j] = disp_valid[j] && disp_ready[j];
    end else begin : g_next
      assign fire[j] = disp_valid[j] && disp_ready[j] && fire[j-1];
    end
  end

  always_comb begin
    pop_n = '0;
    for (int j = 0; j < RD_W; j++) if (fire[j]) pop_n = POP_W'(j + 1);
  end

  // R4
  take_le_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_n <= req_cnt);
  // R3
  throttle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    throttle |=> count <= $past(count));
  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0);
  // R8
  flush_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (throttle || flush || req_cnt == REQ_W'(CAP)));
endmodule

// File: tb/test_insn_queue.sv
`timescale 1ns/1ps
module test_insn_queue;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         throttle = 1'b0;
  logic         flush = 1'b0;
  logic [2:0]   req_cnt;
  logic [3:0]   rsp_valid = '0;
  logic [127:0] rsp_insn = '0;
  logic [1:0]   disp_valid;
  logic [1:0]   disp_ready = '0;
  logic [63:0]  disp_insn;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int mq[$];
  int mfree = 6;
  int base = 100;

  always #10 clk = ~clk;

  insn_queue i_insn_queue (
    .clk(clk), .rst_n(rst_n), .throttle(throttle), .flush(flush), .req_cnt(req_cnt),
    .rsp_valid(rsp_valid), .rsp_insn(rsp_insn), .disp_valid(disp_valid),
    .disp_ready(disp_ready), .disp_insn(disp_insn));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit thr, input bit fl, input logic [3:0] vl, input logic [1:0] rdy);
    int exp_req, take, npop;
    bit v0, v1, f0, f1, run;
    @(negedge clk);
    throttle = thr; flush = fl; rsp_valid = vl; disp_ready = rdy;
    for (int i = 0; i < 4; i++) rsp_insn[i*32 +: 32] = base + i;
    #2;
    exp_req = (thr || fl) ? 0 : ((mfree > 4) ? 4 : mfree);
    if (fl)       check(req_cnt == exp_req, "R8 req", req_cnt, exp_req);
    else if (thr) check(req_cnt == exp_req, "R3 req", req_cnt, exp_req);
    else          check(req_cnt == exp_req, "R2 req", req_cnt, exp_req);
    v0 = !fl && mq.size() >= 1;
    v1 = !fl && mq.size() >= 2;
    check(disp_valid[0] == v0, fl ? "R8 v0" : "R6 v0", disp_valid[0], v0);
    check(disp_valid[1] == v1, fl ? "R8 v1" : "R6 v1", disp_valid[1], v1);
    if (v0) check(disp_insn[31:0] == mq[0], "R5 slot0", disp_insn[31:0], mq[0]);
    if (v1) check(disp_insn[63:32] == mq[1], "R5 slot1", disp_insn[63:32], mq[1]);
    take = 0; run = 1;
    for (int i = 0; i < 4; i++)
      if (run && vl[i] && i < exp_req) take = i + 1; else run = 0;
    f0 = v0 && rdy[0];
    f1 = v1 && rdy[1] && f0;
    npop = int'(f0) + int'(f1);
    if (fl) begin
      mq.delete();
      mfree = 6;
    end else begin
      for (int k = 0; k < npop; k++) void'(mq.pop_front());
      for (int i = 0; i < take; i++) mq.push_back(base + i);
      mfree = 6 - mq.size();
    end
    check(mq.size() <= 6, "R9 occupancy", mq.size(), 6);
    base += 4;
  endtask

  initial begin
    int n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #2;
    check(disp_valid == 2'b00, "R1 valid", disp_valid, 0);
    check(req_cnt == 3'd4, "R1 req", req_cnt, 4);
    // Directed fill: grants 4, then 2, then 0; one pop frees one entry (R2, R7)
    step(0, 0, 4'hF, 2'b00);
    step(0, 0, 4'hF, 2'b00);
    step(0, 0, 4'hF, 2'b10);
    step(0, 0, 4'hF, 2'b01);
    step(0, 0, 4'hF, 2'b00);
    // Flush while full, then refill (R8)
    step(0, 1, 4'hF, 2'b11);
    step(0, 0, 4'b0101, 2'b00);
    step(1, 0, 4'hF, 2'b11);
    // Sweep of lane patterns against ready patterns (R2..R7)
    for (int thr = 0; thr < 2; thr++)
      for (int rep = 0; rep < 3; rep++)
        for (int vl = 0; vl < 16; vl++)
          for (int rdy = 0; rdy < 4; rdy++) begin
            n++;
            step(thr[0] && (vl[0] ^ rdy[0]), (n % 29) == 28, vl[3:0], rdy[1:0]);
          end
    // Drain (R6, R7)
    repeat (6) step(0, 0, 4'h0, 2'b11);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule